// File: doc/BRIEF.md
# Parallel 8080-Style Panel Write Sequencer

This block turns single write requests into timed write cycles on an 8080-style parallel panel bus. A request carries one register-select bit, which tells the panel whether the word is a command or data, and one data word. It is offered through a valid/ready handshake. Once a request is taken, the block steps the select line, the active-low chip select, the active-low write strobe and the data bus through four timed phases. Each phase lasts its programmed count plus one cycle of the internal clock.

The four phase lengths come from run-time inputs and are captured together with the request. The recommended settings for a fast panel are 0, 0, 1 and 0 for the address, setup, strobe and hold counts. Two further inputs take effect immediately and set the polarity of the transfer-enable output and the pixel-clock output. The block issues writes only and has no read cycle.

Top module: `i80w_writer`

## Requirements
- R1: Out of reset, chip select and write strobe are high (inactive), the data-valid flag is low, the data bus reads zero and the block is ready.
- R2: Ready is high only while no write is in progress. A request is taken on a clock edge where both valid and ready are high, and every request taken produces exactly one write cycle.
- R3: After a request is taken, the select line carries the request's bit while chip select stays high for (address-setup count + 1) cycles.
- R4: Chip select then goes low, and the write strobe stays high for (CS-to-strobe count + 1) cycles. The strobe never falls unless chip select was already low.
- R5: The write strobe is low for (strobe count + 1) cycles.
- R6: After the strobe rises, chip select stays low for (hold count + 1) cycles and then returns high.
- R7: The data bus carries the captured word and the data-valid flag is high from the cycle the strobe falls until chip select rises. At all other times the data bus is zero.
- R8: After chip select rises, ready stays low for exactly one more cycle before the next request can be taken.
- R9: The four phase counts and the data word are captured when the request is taken. Changes on those inputs during the write do not alter that write.
- R10: The transfer-enable output equals the data-valid flag XOR the enable-invert input, and the invert input takes effect at once.
- R11: The pixel-clock output toggles on every clock edge, and the clock-invert input flips its level at once.
- R12: The write strobe is low only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal video clock; all phases are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block can take a request |
| req_is_cmd | input | 1 | Register-select bit for this write |
| req_data | input | DATA_W | Word to write |
| cfg_addr_setup | input | 4 | Address-to-chip-select count |
| cfg_cs_to_we | input | 4 | Chip-select-to-strobe count |
| cfg_we_active | input | 4 | Strobe-low count |
| cfg_we_hold | input | 4 | Strobe-release-to-chip-select-release count |
| cfg_inv_en | input | 1 | Invert the transfer-enable output |
| cfg_inv_clk | input | 1 | Invert the pixel-clock output |
| bus_rs | output | 1 | Register-select line to the panel |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_data | output | DATA_W | Data bus |
| bus_data_oe | output | 1 | Data-valid flag |
| bus_den | output | 1 | Transfer-enable output, polarity programmable |
| bus_pclk | output | 1 | Pixel-clock output, polarity programmable |

## Verification
The assertions assume the phase counts are held inside a write only where the requirements demand it. They depend on the captured copy, so the inputs may change freely once a request has been taken. They also assume that valid is raised only between clock edges, and that the polarity inputs change only while the bus is idle. The stimulus drives every input at the falling clock edge. It holds valid until an edge on which ready is high, and in one write it deliberately scrambles the phase counts and the data word immediately after acceptance. The stimulus changes the polarity inputs only once all writes have drained.

// File: rtl/i80w_pkg.sv
package i80w_pkg;

    localparam int PH_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic [PH_W-1:0] addr_setup;
        logic [PH_W-1:0] cs_to_we;
        logic [PH_W-1:0] we_active;
        logic [PH_W-1:0] we_hold;
    } timing_t;

    typedef struct packed {
        phase_e          ph;
        logic [PH_W-1:0] cnt;
        timing_t         tim;
    } seq_state_t;

    function automatic logic cs_on(input phase_e p);
        return (p == PH_SETUP) || (p == PH_STROBE) || (p == PH_HOLD);
    endfunction

    function automatic logic drive_on(input phase_e p);
        return (p == PH_STROBE) || (p == PH_HOLD);
    endfunction

endpackage

// File: rtl/i80w_phase_seq.sv
module i80w_phase_seq
    import i80w_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  timing_t cfg,
    output phase_e  phase
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph  = PH_ADDR;
                    st_d.tim = cfg;
                    st_d.cnt = cfg.addr_setup;
                end
            end
            PH_ADDR: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_SETUP;
                    st_d.cnt = st_q.tim.cs_to_we;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_STROBE;
                    st_d.cnt = st_q.tim.we_active;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_HOLD;
                    st_d.cnt = st_q.tim.we_hold;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) begin
                    st_d.ph = PH_GAP;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_GAP:  st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, tim: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;

    // R9: captured timing does not move while a write is in flight
    assert_timing_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_IDLE && st_q.ph != PH_ADDR) |-> $stable(st_q.tim));

    // R2: a write always begins in the address phase
    assert_enter_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && start) |=> (st_q.ph == PH_ADDR));

endmodule

// File: rtl/i80w_pin_drv.sv
module i80w_pin_drv
    import i80w_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  phase_e            phase,
    input  logic              is_cmd,
    input  logic [DATA_W-1:0] data_in,
    input  logic              inv_en,
    input  logic              inv_clk,
    output logic              rs,
    output logic              cs_n,
    output logic              we_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              den,
    output logic              pclk
);

    typedef struct packed {
        logic              cmd;
        logic [DATA_W-1:0] word;
        logic              tog;
    } pin_state_t;

    pin_state_t pin_d, pin_q;

    always_comb begin
        pin_d     = pin_q;
        pin_d.tog = ~pin_q.tog;
        if (capture) begin
            pin_d.cmd  = is_cmd;
            pin_d.word = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign rs       = pin_q.cmd;
    assign cs_n     = ~cs_on(phase);
    assign we_n     = ~(phase == PH_STROBE);
    assign data_oe  = drive_on(phase);
    assign data_out = data_oe ? pin_q.word : '0;
    assign den      = data_oe ^ inv_en;
    assign pclk     = pin_q.tog ^ inv_clk;

    // R12: strobe only inside chip select
    assert_we_within_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cs_n);

    // R4: strobe falls only after chip select was already low
    assert_we_after_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(!cs_n));

    // R7: data is steady while flagged valid
    assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe)) |-> $stable(data_out));

    // R11: pixel clock register alternates every edge
    assert_pclk_toggle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(inv_clk) |=> (pclk != $past(pclk)));

endmodule

// File: rtl/i80w_writer.sv
module i80w_writer
    import i80w_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_cmd,
    input  logic [DATA_W-1:0] req_data,
    input  logic [PH_W-1:0]   cfg_addr_setup,
    input  logic [PH_W-1:0]   cfg_cs_to_we,
    input  logic [PH_W-1:0]   cfg_we_active,
    input  logic [PH_W-1:0]   cfg_we_hold,
    input  logic              cfg_inv_en,
    input  logic              cfg_inv_clk,
    output logic              bus_rs,
    output logic              bus_cs_n,
    output logic              bus_we_n,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_data_oe,
    output logic              bus_den,
    output logic              bus_pclk
);

    phase_e  phase;
    timing_t tim_in;
    logic    take;

    assign tim_in    = '{addr_setup: cfg_addr_setup, cs_to_we: cfg_cs_to_we,
                         we_active: cfg_we_active, we_hold: cfg_we_hold};
    assign req_ready = (phase == PH_IDLE);
    assign take      = req_valid && req_ready;

    i80w_phase_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (take),
        .cfg   (tim_in),
        .phase (phase)
    );

    i80w_pin_drv #(.DATA_W(DATA_W)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (take),
        .phase    (phase),
        .is_cmd   (req_is_cmd),
        .data_in  (req_data),
        .inv_en   (cfg_inv_en),
        .inv_clk  (cfg_inv_clk),
        .rs       (bus_rs),
        .cs_n     (bus_cs_n),
        .we_n     (bus_we_n),
        .data_out (bus_data),
        .data_oe  (bus_data_oe),
        .den      (bus_den),
        .pclk     (bus_pclk)
    );

    // R2: ready never overlaps an active bus
    assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && bus_we_n && !bus_data_oe));

    // R8: one idle cycle follows chip-select release
    assert_gap_after_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> !req_ready);

    // R2: a taken request removes ready on the next cycle
    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/i80w_writer_tb.sv
module i80w_writer_tb;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_is_cmd = 1'b0;
    logic [DW-1:0] req_data = '0;
    logic [3:0]    c_as = '0, c_cw = '0, c_wa = 4'd1, c_wh = '0;
    logic          inv_en = 1'b0, inv_clk = 1'b0;
    logic          bus_rs, bus_cs_n, bus_we_n, bus_data_oe, bus_den, bus_pclk;
    logic [DW-1:0] bus_data;

    always #10 clk = ~clk;

    i80w_writer #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_cmd(req_is_cmd), .req_data(req_data),
        .cfg_addr_setup(c_as), .cfg_cs_to_we(c_cw), .cfg_we_active(c_wa),
        .cfg_we_hold(c_wh), .cfg_inv_en(inv_en), .cfg_inv_clk(inv_clk),
        .bus_rs(bus_rs), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
        .bus_data(bus_data), .bus_data_oe(bus_data_oe), .bus_den(bus_den),
        .bus_pclk(bus_pclk)
    );

    typedef struct packed {
        logic          cmd;
        logic [DW-1:0] word;
        logic [3:0]    as, cw, wa, wh;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   driven = 0;
    int   done_cnt = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // driver: offer one write, push its expectation
    task automatic do_write(input logic cmd, input logic [DW-1:0] w,
                            input logic [3:0] a, input logic [3:0] b,
                            input logic [3:0] c, input logic [3:0] d,
                            input bit scramble);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_is_cmd = cmd; req_data = w;
        c_as = a; c_cw = b; c_wa = c; c_wh = d;
        req_valid = 1'b1;
        exp_q.push_back('{cmd: cmd, word: w, as: a, cw: b, wa: c, wh: d});
        driven++;
        @(negedge clk);
        req_valid = 1'b0;
        if (scramble) begin
            c_as = ~a; c_cw = ~b; c_wa = ~c; c_wh = ~d;
            req_data = ~w; req_is_cmd = ~cmd;
        end
    endtask

    // monitor: measure each phase at the falling edge
    int   mst = 0;
    int   ca, cb, cc, cd, cg, derr, rerr;
    exp_t cur;

    always @(negedge clk) begin
        if (rst_n) begin
            case (mst)
                0: if (!req_ready && bus_cs_n) begin
                       mst = 1; ca = 1; cb = 0; cc = 0; cd = 0; cg = 0;
                       derr = 0; rerr = 0;
                       cur = (exp_q.size() > 0) ? exp_q[0] : '0;
                       if (bus_rs != cur.cmd) rerr++;
                       if (bus_data != '0) derr++;
                   end
                1: begin
                       if (bus_rs != cur.cmd) rerr++;
                       if (bus_cs_n) ca++;
                       else begin mst = 2; cb = 1; end
                       if (bus_data_oe || bus_data != '0) derr++;
                   end
                2: begin
                       if (bus_rs != cur.cmd) rerr++;
                       if (!bus_we_n) begin mst = 3; cc = 1; end
                       else cb++;
                       if (bus_we_n && (bus_data_oe || bus_data != '0)) derr++;
                   end
                3: begin
                       if (bus_rs != cur.cmd) rerr++;
                       if (!bus_we_n) cc++;
                       else if (!bus_cs_n) begin mst = 4; cd = 1; end
                       else begin mst = 5; cg = 1; end
                   end
                4: begin
                       if (!bus_cs_n) cd++;
                       else begin mst = 5; cg = 1; end
                   end
                5: begin
                       if (!req_ready) cg++;
                       else begin
                           void'(exp_q.pop_front());
                           done_cnt++;
                           check(ca == int'(cur.as) + 1, "R3 address phase", ca, int'(cur.as) + 1);
                           check(cb == int'(cur.cw) + 1, "R4 cs-to-strobe", cb, int'(cur.cw) + 1);
                           check(cc == int'(cur.wa) + 1, "R5 strobe low", cc, int'(cur.wa) + 1);
                           check(cd == int'(cur.wh) + 1, "R6 hold", cd, int'(cur.wh) + 1);
                           check(cg == 1, "R8 idle gap", cg, 1);
                           check(derr == 0, "R7 data bus", derr, 0);
                           check(rerr == 0, "R9 select bit held", rerr, 0);
                           mst = 0;
                       end
                   end
                default: mst = 0;
            endcase
            if (mst == 3 || mst == 4) begin
                if (bus_data != cur.word || !bus_data_oe) derr++;
                if (bus_den != 1'b1) derr++;
            end
            if (mst == 5 && (bus_data_oe || bus_data != '0)) derr++;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            check(0, "watchdog", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic p0, p1;
        repeat (2) @(negedge clk);
        // R1: reset state
        check(bus_cs_n && bus_we_n, "R1 cs/we idle high", {bus_cs_n, bus_we_n}, 3);
        check(!bus_data_oe && bus_data == '0, "R1 data idle", int'(bus_data), 0);
        check(req_ready, "R1 ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R2 ready when idle", req_ready, 1);

        do_write(1'b1, 16'h002C, 4'd0, 4'd0, 4'd1, 4'd0, 1'b0);
        do_write(1'b0, 16'hA5C3, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0);
        do_write(1'b0, 16'hFFFF, 4'd15, 4'd15, 4'd15, 4'd15, 1'b0);
        do_write(1'b1, 16'h1234, 4'd3, 4'd1, 4'd4, 4'd2, 1'b0);
        // R9: inputs scrambled right after acceptance
        do_write(1'b0, 16'h0F0F, 4'd2, 4'd5, 4'd0, 4'd7, 1'b1);
        do_write(1'b1, 16'h8001, 4'd1, 4'd0, 4'd2, 4'd1, 1'b1);

        while (exp_q.size() > 0 || mst != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        check(done_cnt == driven, "R2 one cycle per request", done_cnt, driven);
        check(bus_data == '0 && !bus_data_oe, "R7 data zero when idle", int'(bus_data), 0);

        // R10: enable polarity
        check(bus_den == 1'b0, "R10 den idle", bus_den, 0);
        inv_en = 1'b1; #1;
        check(bus_den == 1'b1, "R10 den inverted", bus_den, 1);
        inv_en = 1'b0;

        // R11: clock output toggles and inverts
        @(negedge clk); p0 = bus_pclk;
        @(negedge clk); p1 = bus_pclk;
        check(p0 != p1, "R11 pclk toggles", p1, !p0);
        inv_clk = 1'b1; #1;
        check(bus_pclk == !p1, "R11 pclk inverted", bus_pclk, !p1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule